// File: doc/BRIEF.md
# Dual Event Performance Counter Unit

This unit keeps two 32-bit event counters for a processor core. A single mode-control word sets the behaviour of both counters. It holds a 7-bit event code for the first counter and a 6-bit event code for the second. It also holds a 2-bit field that picks which time-base bit is watched, one global interrupt enable, and one interrupt-control bit per counter. On each clock, every counter adds the amount its code selects. The amount comes from one of these sources:

- a cycle tick
- the number of instructions completed (0 to 2)
- the number of instructions dispatched (0 to 2)
- a rising edge of a chosen bit of the 64-bit time base
- a one-cycle event strobe

Software reaches the mode word and both counters through a small register port. Writes take effect on the next clock edge, and reads are combinational. A counter counts as overflowed once its top bit is set. The interrupt line rises when the global enable is set and an overflowed counter has its own interrupt-control bit set. From then on, both counters freeze until software writes the mode word again.

Top module: `evt_perf_pair`

## Requirements
- R1: After reset, the mode word, both counters and `irq` read as zero.
- R2: Register addresses: 0 is the mode word, 1 is counter A, 2 is counter B, and 3 reads as zero. A write shows on `reg_rdata` after the next rising edge. The mode word keeps only bits [6:0] (code A), [13:8] (code B), [17:16] (time-base pick), 24 (global enable), 25 (interrupt control A) and 26 (interrupt control B). All other bits read as zero.
- R3: Code 0 holds a counter. A code outside the defined set adds nothing.
- R4: Code 1 adds `cyc_tick` each cycle. Code 2 adds `cmpl_cnt` each cycle.
- R5: Code 4 adds `disp_cnt` (0, 1 or 2) in one cycle.
- R6: Code 3 adds one for each 0-to-1 change of the picked time-base bit, counted against the previous cycle. Pick values 0/1/2/3 select `tb_value` bits 0/8/12/16 for counter A and 16/12/8/0 for counter B (bit 63 is the most significant).
- R7: A mode-word write reloads the stored previous value of the newly picked bit. Changing the pick therefore never produces an edge by itself.
- R8: On counter A, codes 5 to 12 add `evt_strobe[code-5]`. On counter B, every code above 4 adds nothing.
- R9: `irq` = global enable AND ((A[31] AND control A) OR (B[31] AND control B)). It is combinational from the stored state.
- R10: While `irq` is high, and from then on until the next mode-word write, neither counter advances. A mode-word write releases the freeze.
- R11: A counter loaded by software with its top bit already set raises `irq` on the next cycle if the enables allow it, without any event being counted.
- R12: In a cycle that writes the mode word, neither counter advances. In a cycle that writes a counter, the written value replaces any count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_tick | input | 1 | Processor cycle tick |
| cmpl_cnt | input | 2 | Instructions completed this cycle, 0 to 2 |
| disp_cnt | input | 2 | Instructions dispatched this cycle, 0 to 2 |
| evt_strobe | input | 8 | One-cycle event strobes for counter A codes 5 to 12 |
| tb_value | input | 64 | Time-base value |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| irq | output | 1 | Overflow interrupt request |

## Verification
The assertions assume that `cmpl_cnt` and `disp_cnt` never carry the value 3. An input-range assertion checks this, and the stimulus draws both only from 0 to 2. The step-size and freeze properties also assume that software writes the counters only through the port. Every such write is excluded from the antecedent.

The random phase holds the event codes mostly within the defined set, with a few reserved values. It loads counter values just below the overflow point so that the freeze and the release paths run many times. It flips only the low time-base bits so that the picked bits change often.

// File: rtl/evt_perf_pkg.sv
package evt_perf_pkg;

  localparam int SEL_W  = 7;
  localparam int STRB_N = 8;
  localparam int TB_W   = 64;
  localparam int MODE_W = 32;

  typedef struct packed {
    logic [4:0] rsv_hi;
    logic       ic_b;
    logic       ic_a;
    logic       gen;
    logic [5:0] rsv_m;
    logic [1:0] pick;
    logic [1:0] rsv_l;
    logic [5:0] code_b;
    logic       rsv_z;
    logic [6:0] code_a;
  } mode_t;

  localparam logic [MODE_W-1:0] MODE_KEEP = 32'h0703_3F7F;
  localparam logic [1:0] ADR_MODE = 2'd0;
  localparam logic [1:0] ADR_CNTA = 2'd1;

  // position of the watched time-base bit, bit 63 = most significant
  function automatic logic [5:0] tb_index(input logic second, input logic [1:0] pick);
    logic [5:0] r;
    case (pick)
      2'd0: r = second ? 6'd16 : 6'd0;
      2'd1: r = second ? 6'd12 : 6'd8;
      2'd2: r = second ? 6'd8  : 6'd12;
      default: r = second ? 6'd0 : 6'd16;
    endcase
    return r;
  endfunction

  function automatic logic [1:0] evt_amount(input logic [SEL_W-1:0] code,
                                            input logic has_strb,
                                            input logic tick,
                                            input logic [1:0] cmpl,
                                            input logic [1:0] disp,
                                            input logic tb_rise,
                                            input logic [STRB_N-1:0] strb);
    logic [SEL_W-1:0] off;
    logic [1:0] r;
    off = code - SEL_W'(5);
    case (code)
      7'd0: r = 2'd0;
      7'd1: r = {1'b0, tick};
      7'd2: r = cmpl;
      7'd3: r = {1'b0, tb_rise};
      7'd4: r = disp;
      default: r = (has_strb && code <= 7'd12) ? {1'b0, strb[off[2:0]]} : 2'd0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/evt_tb_edge.sv
module evt_tb_edge
  import evt_perf_pkg::*;
#(
  parameter bit SECOND = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TB_W-1:0] tb_value,
  input  logic [1:0]      pick,
  input  logic            reload,
  input  logic [1:0]      reload_pick,
  output logic            tb_rise
);

  logic cur_bit;
  logic prev_q;

  assign cur_bit = tb_value[tb_index(SECOND, pick)];
  assign tb_rise = cur_bit & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      prev_q <= 1'b0;
    else if (reload) prev_q <= tb_value[tb_index(SECOND, reload_pick)];
    else             prev_q <= cur_bit;
  end

  AST_EDGE_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    (tb_rise && !reload) |=> !tb_rise); // R6

endmodule

// File: rtl/evt_counter.sv
module evt_counter
  import evt_perf_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter bit HAS_STRB = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  code,
  input  logic              hold,
  input  logic              wr,
  input  logic [CNT_W-1:0]  wdata,
  input  logic              tick,
  input  logic [1:0]        cmpl,
  input  logic [1:0]        disp,
  input  logic              tb_rise,
  input  logic [STRB_N-1:0] strb,
  output logic [CNT_W-1:0]  count,
  output logic              ovf
);

  logic [1:0]       step_amt;
  logic [CNT_W-1:0] count_q;

  assign step_amt = evt_amount(code, HAS_STRB, tick, cmpl, disp, tb_rise, strb);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count_q <= '0;
    else if (wr)   count_q <= wdata;
    else if (!hold) count_q <= count_q + CNT_W'(step_amt);
  end

  assign count = count_q;
  assign ovf   = count_q[CNT_W-1];

  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !wr) |=> (count == $past(count))); // R10

  AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (code == '0 && !wr) |=> (count == $past(count))); // R3

  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> ((count - $past(count)) <= CNT_W'(2))); // R5

endmodule

// File: rtl/evt_perf_pair.sv
module evt_perf_pair
  import evt_perf_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_tick,
  input  logic [1:0]        cmpl_cnt,
  input  logic [1:0]        disp_cnt,
  input  logic [STRB_N-1:0] evt_strobe,
  input  logic [TB_W-1:0]   tb_value,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  output logic              irq
);

  localparam int N_CNT = 2;

  mode_t            mode_q;
  mode_t            mode_new;
  logic             frozen_q;
  logic             mode_wr;
  logic             hold_all;
  logic             irq_req;
  logic [N_CNT-1:0] ovf;
  logic [N_CNT-1:0] cnt_wr;
  logic [N_CNT-1:0] tb_rise;
  logic [CNT_W-1:0] cnt_val [N_CNT];

  assign mode_wr  = reg_wr && (reg_addr == ADR_MODE);
  assign mode_new = mode_t'(reg_wdata[MODE_W-1:0] & MODE_KEEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (mode_wr) mode_q <= mode_new;
  end

  // overflow interrupt and freeze
  assign irq_req  = mode_q.gen & ((ovf[0] & mode_q.ic_a) | (ovf[1] & mode_q.ic_b));
  assign hold_all = frozen_q | irq_req | mode_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       frozen_q <= 1'b0;
    else if (mode_wr) frozen_q <= 1'b0;
    else if (irq_req) frozen_q <= 1'b1;
  end

  for (genvar i = 0; i < N_CNT; i++) begin : g_cnt
    logic [SEL_W-1:0] code_i;
    if (i == 0) begin : g_a
      assign code_i = mode_q.code_a;
    end else begin : g_b
      assign code_i = {1'b0, mode_q.code_b};
    end

    assign cnt_wr[i] = reg_wr && (reg_addr == ADR_CNTA + 2'(i));

    evt_tb_edge #(.SECOND(i != 0)) u_edge (
      .clk        (clk),
      .rst_n      (rst_n),
      .tb_value   (tb_value),
      .pick       (mode_q.pick),
      .reload     (mode_wr),
      .reload_pick(mode_new.pick),
      .tb_rise    (tb_rise[i])
    );

    evt_counter #(.CNT_W(CNT_W), .HAS_STRB(i == 0)) u_ctr (
      .clk    (clk),
      .rst_n  (rst_n),
      .code   (code_i),
      .hold   (hold_all),
      .wr     (cnt_wr[i]),
      .wdata  (reg_wdata),
      .tick   (cyc_tick),
      .cmpl   (cmpl_cnt),
      .disp   (disp_cnt),
      .tb_rise(tb_rise[i]),
      .strb   (evt_strobe),
      .count  (cnt_val[i]),
      .ovf    (ovf[i])
    );
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = CNT_W'(mode_q);
      2'd1:    reg_rdata = cnt_val[0];
      2'd2:    reg_rdata = cnt_val[1];
      default: reg_rdata = '0;
    endcase
  end

  assign irq = irq_req;

  AST_IRQ_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !reg_wr) |=> irq); // R10

  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_cnt != 2'd3) && (cmpl_cnt != 2'd3)); // R5

endmodule

// File: tb/evt_perf_pair_tb.sv
module evt_perf_pair_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cyc_tick = 1'b0;
  logic [1:0]  cmpl_cnt = '0;
  logic [1:0]  disp_cnt = '0;
  logic [7:0]  evt_strobe = '0;
  logic [63:0] tb_value = '0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int n_checks = 0;
  int n_err = 0;
  bit done = 1'b0;

  logic [31:0] m_mode;
  logic [31:0] m_c [2];
  logic        m_prev [2];
  logic        m_frozen;

  always #10 clk = ~clk;

  evt_perf_pair u_dut (
    .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .cmpl_cnt(cmpl_cnt),
    .disp_cnt(disp_cnt), .evt_strobe(evt_strobe), .tb_value(tb_value),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  // watched bit, written as a big-endian position first
  function automatic int b_tb_pos(int ctr, logic [1:0] pick);
    int be;
    if (ctr == 0) be = 32 + ((pick == 0) ? 31 : (pick == 1) ? 23 : (pick == 2) ? 19 : 15);
    else          be = (pick == 0) ? 47 : (pick == 1) ? 51 : (pick == 2) ? 55 : 63;
    return 63 - be;
  endfunction

  function automatic int b_amount(int ctr, int code, logic rise);
    if (code == 1) return int'(cyc_tick);
    if (code == 2) return int'(cmpl_cnt);
    if (code == 3) return int'(rise);
    if (code == 4) return int'(disp_cnt);
    if (ctr == 0 && code >= 5 && code <= 12) return int'(evt_strobe[code-5]);
    return 0;
  endfunction

  function automatic logic b_irq();
    return m_mode[24] & ((m_c[0][31] & m_mode[25]) | (m_c[1][31] & m_mode[26]));
  endfunction

  task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one clock: model computed from current inputs, applied at the edge
  task automatic step();
    logic        wm, stop, cur;
    logic [31:0] nc [2];
    logic        np [2];
    int          code;
    wm   = reg_wr && reg_addr == 2'd0;
    stop = m_frozen | b_irq() | wm;
    for (int k = 0; k < 2; k++) begin
      code = (k == 0) ? int'(m_mode[6:0]) : int'(m_mode[13:8]);
      cur = tb_value[b_tb_pos(k, m_mode[17:16])];
      nc[k] = stop ? m_c[k] : m_c[k] + 32'(b_amount(k, code, cur & ~m_prev[k]));
      if (reg_wr && int'(reg_addr) == k + 1) nc[k] = reg_wdata;
      np[k] = wm ? tb_value[b_tb_pos(k, reg_wdata[17:16])] : cur;
    end
    @(posedge clk);
    m_frozen = wm ? 1'b0 : (m_frozen | b_irq());
    if (wm) m_mode = reg_wdata & 32'h0703_3F7F;
    for (int k = 0; k < 2; k++) begin
      m_c[k] = nc[k];
      m_prev[k] = np[k];
    end
    @(negedge clk);
  endtask

  task automatic check(string tag);
    reg_wr = 1'b0;
    reg_addr = 2'd0; #1; cmp(tag, reg_rdata, m_mode);
    reg_addr = 2'd1; #1; cmp(tag, reg_rdata, m_c[0]);
    reg_addr = 2'd2; #1; cmp(tag, reg_rdata, m_c[1]);
    cmp(tag, {31'd0, irq}, {31'd0, b_irq()});
  endtask

  task automatic cyc(logic wr, logic [1:0] adr, logic [31:0] wd, string tag);
    reg_wr = wr; reg_addr = adr; reg_wdata = wd;
    step();
    check(tag);
  endtask

  function automatic logic [31:0] mode_word(int ca, int cb, int pick, bit ge, bit ia, bit ib);
    return 32'(ca) | (32'(cb) << 8) | (32'(pick) << 16) | (32'(ge) << 24)
         | (32'(ia) << 25) | (32'(ib) << 26);
  endfunction

  task automatic rand_events();
    cyc_tick   = 1'($urandom_range(0, 1));
    cmpl_cnt   = 2'($urandom_range(0, 2));
    disp_cnt   = 2'($urandom_range(0, 2));
    evt_strobe = 8'($urandom);
    tb_value   = tb_value ^ {47'd0, 17'($urandom)};
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] keep;
    void'($urandom(32'd2468));
    m_mode = '0; m_frozen = 1'b0;
    for (int k = 0; k < 2; k++) begin m_c[k] = '0; m_prev[k] = 1'b0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1");
    cmp("R1", {31'd0, irq}, 32'd0);

    // register port
    cyc(1'b1, 2'd1, 32'h0000_1234, "R2");
    cmp("R2", m_c[0], 32'h0000_1234);
    cyc(1'b1, 2'd2, 32'h0000_ABCD, "R2");
    cyc(1'b1, 2'd0, 32'hFFFF_FFFF & ~32'h0700_0000, "R2");
    reg_addr = 2'd0; #1; cmp("R2", reg_rdata, 32'h0003_3F7F);
    reg_addr = 2'd3; #1; cmp("R2", reg_rdata, 32'd0);

    // hold and reserved codes
    cyc_tick = 1'b1; cmpl_cnt = 2'd2; disp_cnt = 2'd2; evt_strobe = 8'hFF;
    cyc(1'b1, 2'd0, mode_word(0, 0, 0, 0, 0, 0), "R3");
    keep = m_c[0];
    for (int i = 0; i < 3; i++) cyc(1'b0, 2'd0, 32'd0, "R3");
    cmp("R3", m_c[0], keep);
    cyc(1'b1, 2'd0, mode_word(13, 40, 0, 0, 0, 0), "R3");
    for (int i = 0; i < 3; i++) cyc(1'b0, 2'd0, 32'd0, "R3");

    // cycles and completions
    cyc(1'b1, 2'd0, mode_word(1, 2, 0, 0, 0, 0), "R4");
    for (int i = 0; i < 12; i++) begin rand_events(); cyc(1'b0, 2'd0, 32'd0, "R4"); end

    // dispatch up to two per cycle
    cyc(1'b1, 2'd0, mode_word(4, 4, 0, 0, 0, 0), "R5");
    keep = m_c[1];
    disp_cnt = 2'd2;
    cyc(1'b0, 2'd0, 32'd0, "R5");
    cmp("R5", m_c[1], keep + 32'd2);
    for (int i = 0; i < 12; i++) begin rand_events(); cyc(1'b0, 2'd0, 32'd0, "R5"); end

    // time-base edges for each pick
    for (int p = 0; p < 4; p++) begin
      tb_value = '0;
      cyc(1'b1, 2'd0, mode_word(3, 3, p, 0, 0, 0), "R6");
      tb_value = '1;
      cyc(1'b0, 2'd0, 32'd0, "R6");
      for (int i = 0; i < 10; i++) begin rand_events(); cyc(1'b0, 2'd0, 32'd0, "R6"); end
    end

    // pick change with every bit high: no false edge
    tb_value = '1;
    cyc(1'b1, 2'd0, mode_word(3, 3, 0, 0, 0, 0), "R7");
    cyc(1'b0, 2'd0, 32'd0, "R7");
    keep = m_c[0];
    cyc(1'b1, 2'd0, mode_word(3, 3, 2, 0, 0, 0), "R7");
    cyc(1'b0, 2'd0, 32'd0, "R7");
    cyc(1'b1, 2'd0, mode_word(3, 3, 3, 0, 0, 0), "R7");
    cyc(1'b0, 2'd0, 32'd0, "R7");
    cmp("R7", m_c[0], keep);

    // strobes on counter A, reserved on counter B
    for (int c = 5; c <= 12; c++) begin
      cyc(1'b1, 2'd0, mode_word(c, c + 4, 0, 0, 0, 0), "R8");
      for (int i = 0; i < 4; i++) begin rand_events(); cyc(1'b0, 2'd0, 32'd0, "R8"); end
    end

    // enable gating: ge clear, no irq
    cyc_tick = 1'b1;
    cyc(1'b1, 2'd1, 32'h7FFF_FFFE, "R9");
    cyc(1'b1, 2'd0, mode_word(1, 0, 0, 0, 1, 0), "R9");
    for (int i = 0; i < 4; i++) cyc(1'b0, 2'd0, 32'd0, "R9");
    cmp("R9", {31'd0, irq}, 32'd0);

    // overflow by counting raises irq and freezes
    cyc(1'b1, 2'd1, 32'h7FFF_FFFE, "R10");
    cyc(1'b1, 2'd0, mode_word(1, 1, 0, 1, 1, 0), "R10");
    for (int i = 0; i < 6; i++) cyc(1'b0, 2'd0, 32'd0, "R10");
    cmp("R9", {31'd0, irq}, 32'd1);
    cmp("R10", m_c[0], 32'h8000_0000);
    cyc(1'b1, 2'd1, 32'd5, "R10");
    keep = m_c[1];
    for (int i = 0; i < 3; i++) cyc(1'b0, 2'd0, 32'd0, "R10");
    cmp("R10", m_c[1], keep);
    cyc(1'b1, 2'd0, mode_word(1, 1, 0, 0, 0, 0), "R10");
    for (int i = 0; i < 3; i++) cyc(1'b0, 2'd0, 32'd0, "R10");
    cmp("R10", m_c[0], 32'd8);

    // software-loaded overflow
    cyc(1'b1, 2'd0, mode_word(0, 0, 0, 1, 0, 1), "R11");
    keep = m_c[0];
    cyc(1'b1, 2'd2, 32'h8000_0000, "R11");
    cmp("R11", {31'd0, irq}, 32'd1);
    cmp("R11", m_c[0], keep);
    cyc(1'b1, 2'd0, 32'd0, "R11");

    // write cycles override counting
    cyc_tick = 1'b1;
    cyc(1'b1, 2'd0, mode_word(1, 1, 0, 0, 0, 0), "R12");
    keep = m_c[0];
    cyc(1'b1, 2'd0, mode_word(1, 1, 1, 0, 0, 0), "R12");
    cmp("R12", m_c[0], keep);
    cyc(1'b1, 2'd2, 32'h0000_0777, "R12");
    cmp("R12", m_c[1], 32'h0000_0777);

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      int r;
      logic [31:0] wd;
      rand_events();
      r = $urandom_range(0, 99);
      if (r < 3) begin
        wd = $urandom;
        wd[6:0] = 7'($urandom_range(0, 14));
        wd[13:8] = 6'($urandom_range(0, 6));
        cyc(1'b1, 2'd0, wd, "RAND(R9)");
      end else if (r < 6) begin
        cyc(1'b1, 2'($urandom_range(1, 2)), 32'h7FFF_FFF0 + 32'($urandom_range(0, 40)), "RAND(R2)");
      end else begin
        cyc(1'b0, 2'd0, 32'd0, "RAND(R10)");
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

endmodule